// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock line level for an I2C controller in standard, fast and high-speed operation. The low and high halves of each clock period are programmed separately, so the period can be unequal. The low half is a programmed count plus a fixed offset of seven, and the high half is a programmed count plus a fixed offset of five. Two 16-bit configuration words supply the counts, one for the low half and one for the high half. Each word holds a high-speed count in its upper byte and a standard/fast count in its lower byte.

In standard and fast operation the generator counts pulses of a clock-enable tick that comes from the prescaled internal clock. In high-speed operation it counts every cycle of the undivided functional clock and ignores the tick. A high-speed transfer opens with a period timed by the standard/fast byte at a rate near 400 kHz. The controller then raises the high-speed select, and the next period switches to the high-speed byte and the faster time base. The mode and both counts are captured when each low phase opens, so a configuration write never cuts a half-period short.

The generator idles with SCL high. A start request begins a period with its low phase. A stop request releases SCL high and returns the generator to idle. Single-cycle strobes mark each falling and each rising SCL edge, for use by the data-line sequencer.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset, and whenever the generator is idle, `scl_o` is 1 and both strobes are 0.
- R2: A `start` seen while idle, with `stop` low, drives `scl_o` to 0 at the next clock edge. `fall_stb` is 1 for exactly that one cycle.
- R3: A low phase lasts (selected low count + 7) base ticks. Base ticks are counted strictly after the edge that opened the phase.
- R4: A high phase lasts (selected high count + 5) base ticks. It is followed directly by the next low phase.
- R5: When the captured mode is standard/fast, the counts come from bits 7:0 of each word. One base tick is one clock cycle in which `tick` is 1.
- R6: When the captured mode is high-speed, the counts come from bits 15:8 of each word. Every clock cycle is a base tick, and `tick` has no effect.
- R7: `hs_sel` is sampled only when a low phase opens. A change during a period first takes effect in the following period.
- R8: Both configuration words are sampled only when a low phase opens. A change during a period leaves the low and high lengths of that period unchanged.
- R9: `stop` makes `scl_o` 1 at the next edge and returns the generator to idle. If SCL was low, `rise_stb` pulses for that one cycle. No further edges occur until a later `start`. When `start` and `stop` are both 1, `stop` wins.
- R10: `fall_stb` is 1 exactly in the first cycle that `scl_o` reads 0 after being 1. `rise_stb` is 1 exactly in the first cycle that `scl_o` reads 1 after being 0. The two are never 1 together.
- R11: A `start` while a period is running has no effect on the phase lengths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle enable from the prescaled internal clock |
| hs_sel | input | 1 | Selects high-speed timing for the next period |
| start | input | 1 | Begin generating SCL from idle |
| stop | input | 1 | Release SCL high and idle |
| low_cfg | input | 16 | Low counts: [15:8] high-speed, [7:0] standard/fast |
| high_cfg | input | 16 | High counts: [15:8] high-speed, [7:0] standard/fast |
| scl_o | output | 1 | SCL level |
| fall_stb | output | 1 | One-cycle strobe on each falling SCL edge |
| rise_stb | output | 1 | One-cycle strobe on each rising SCL edge |

## Verification
SCL, the strobes and the reaction to `start` and `stop` all change at the first clock edge after the request. A phase then ends at the edge that consumes its last base tick. The bench samples on the falling clock edge, so each level is counted in whole cycles between two observed transitions. A driver queues the expected level and length of each phase. The monitor compares those against the measured run lengths at every transition. In standard/fast runs the first low phase is marked don't-care, because `start` is not aligned to the tick. Every later phase begins on a tick edge, so its length is exactly the tick count times the tick spacing.

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int FW     = 8,
  parameter int LO_OFS = 7,
  parameter int HI_OFS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            hs_sel,
  input  logic            start,
  input  logic            stop,
  input  logic [2*FW-1:0] low_cfg,
  input  logic [2*FW-1:0] high_cfg,
  output logic            scl_o,
  output logic            fall_stb,
  output logic            rise_stb
);
  localparam int CW = FW + 2;

  logic          run, hs_q;
  logic [CW-1:0] cnt, hi_len;
  logic [FW-1:0] lo_fld, hi_fld;
  logic [CW-1:0] lo_load, hi_load;
  logic          step, last, open_low;

  assign lo_fld   = hs_sel ? low_cfg[2*FW-1:FW]  : low_cfg[FW-1:0];
  assign hi_fld   = hs_sel ? high_cfg[2*FW-1:FW] : high_cfg[FW-1:0];
  assign lo_load  = CW'(lo_fld) + CW'(LO_OFS - 1);
  assign hi_load  = CW'(hi_fld) + CW'(HI_OFS - 1);
  assign step     = hs_q | tick;
  assign last     = step && (cnt == '0);
  assign open_low = !stop && ((!run && start) || (run && scl_o && last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      scl_o    <= 1'b1;
      hs_q     <= 1'b0;
      cnt      <= '0;
      hi_len   <= '0;
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
    end else begin
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
      if (stop) begin
        run      <= 1'b0;
        scl_o    <= 1'b1;
        rise_stb <= !scl_o;
      end else if (open_low) begin
        run      <= 1'b1;
        scl_o    <= 1'b0;
        fall_stb <= 1'b1;
        hs_q     <= hs_sel;
        cnt      <= lo_load;
        hi_len   <= hi_load;
      end else if (run && step) begin
        if (cnt == '0) begin
          scl_o    <= 1'b1;
          rise_stb <= 1'b1;
          cnt      <= hi_len;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> scl_o);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (scl_o && !run && !fall_stb));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_stb, rise_stb}));

  // R10
  fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> !scl_o);

  // R10
  rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> scl_o);

  // R3
  low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_stb && !stop) |=> !scl_o);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !open_low) |=> ($stable(hi_len) && $stable(hs_q)));
endmodule

// File: tb/i2c_scl_gen_bench.sv
module i2c_scl_gen_bench;
  localparam int FW = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, hs_sel = 1'b0, start = 1'b0, stop = 1'b0;
  logic [2*FW-1:0] low_cfg = '0, high_cfg = '0;
  logic scl_o, fall_stb, rise_stb;

  typedef struct {
    logic  lvl;
    int    dur;
    string req;
  } item_t;

  item_t exp_q[$];
  int    checks = 0, errors = 0;
  int    tick_per = 4, tcnt = 0;
  bit    mon_on = 1'b0;
  logic  prev_scl = 1'b1;
  int    run_len = 0;

  always #4 clk = ~clk;

  i2c_scl_gen u_i2c_scl_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hs_sel(hs_sel),
    .start(start), .stop(stop), .low_cfg(low_cfg), .high_cfg(high_cfg),
    .scl_o(scl_o), .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  always @(negedge clk) begin
    tcnt <= (tcnt >= tick_per - 1) ? 0 : tcnt + 1;
    tick <= (tcnt == 0);
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(logic lvl, int dur, string req);
    item_t it;
    it.lvl = lvl;
    it.dur = dur;
    it.req = req;
    exp_q.push_back(it);
  endtask

  always @(negedge clk) begin : monitor
    logic  ef, er;
    item_t it;
    if (mon_on) begin
      ef = prev_scl && !scl_o;
      er = !prev_scl && scl_o;
      if (ef || fall_stb) chk("R10 fall strobe", int'(fall_stb), int'(ef));
      if (er || rise_stb) chk("R10 rise strobe", int'(rise_stb), int'(er));
      if (scl_o !== prev_scl) begin
        if (exp_q.size() > 0) begin
          it = exp_q.pop_front();
          chk({it.req, " level"}, int'(prev_scl), int'(it.lvl));
          if (it.dur >= 0) chk({it.req, " length"}, run_len, it.dur);
        end
        run_len = 1;
      end else begin
        run_len++;
      end
      prev_scl = scl_o;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic drain_and_stop();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 scl in reset", int'(scl_o), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 scl after reset", int'(scl_o), 1);
    chk("R1 strobes after reset", int'({fall_stb, rise_stb}), 0);
    prev_scl = scl_o;
    mon_on = 1'b1;
    repeat (4) @(negedge clk);

    // R5 R3 R4: standard/fast timing with tick every 4 cycles
    tick_per = 4;
    low_cfg  = 16'h330B;
    high_cfg = 16'h3304;
    push(1'b1, -1, "R2 idle");
    push(1'b0, -1, "R2 first low");
    push(1'b1, 36, "R4 fs high");
    push(1'b0, 72, "R3 fs low");
    push(1'b1, 36, "R4 fs high");
    push(1'b0, 72, "R5 fs low");
    pulse_start();
    drain_and_stop();

    // R7 R6: first period standard/fast, then high-speed
    tick_per = 3;
    low_cfg  = 16'h0205;
    high_cfg = 16'h0102;
    push(1'b1, -1, "R2 idle");
    push(1'b0, -1, "R7 first low");
    push(1'b1, 21, "R7 first phase high");
    push(1'b0,  9, "R6 hs low");
    push(1'b1,  6, "R6 hs high");
    push(1'b0,  9, "R6 hs low");
    push(1'b1,  6, "R6 hs high");
    pulse_start();
    repeat (2) @(negedge clk);
    hs_sel = 1'b1;
    drain_and_stop();
    hs_sel = 1'b0;

    // R8 R11: mid-period config write and extra start
    tick_per = 2;
    low_cfg  = 16'h1003;
    high_cfg = 16'h1003;
    push(1'b1, -1, "R2 idle");
    push(1'b0, -1, "R8 first low");
    push(1'b1, 16, "R8 old high");
    push(1'b0, 16, "R8 new low");
    push(1'b1, 12, "R8 new high");
    push(1'b0, 16, "R11 low");
    push(1'b1, 12, "R11 high");
    pulse_start();
    repeat (2) @(negedge clk);
    low_cfg  = 16'h1001;
    high_cfg = 16'h1001;
    repeat (25) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    drain_and_stop();

    // R3 R4 R6: high-speed extremes
    hs_sel   = 1'b1;
    low_cfg  = 16'hFF00;
    high_cfg = 16'hFF00;
    push(1'b1, -1, "R2 idle");
    push(1'b0, 262, "R3 hs max low");
    push(1'b1, 260, "R4 hs max high");
    push(1'b0, 262, "R3 hs max low");
    pulse_start();
    drain_and_stop();
    low_cfg  = 16'h00FF;
    high_cfg = 16'h00FF;
    push(1'b1, -1, "R2 idle");
    push(1'b0, 7, "R3 hs min low");
    push(1'b1, 5, "R4 hs min high");
    push(1'b0, 7, "R3 hs min low");
    push(1'b1, 5, "R4 hs min high");
    pulse_start();
    drain_and_stop();
    hs_sel = 1'b0;

    // R2 R9: start latency, stop during low
    tick_per = 4;
    low_cfg  = 16'h0010;
    high_cfg = 16'h0010;
    push(1'b1, -1, "R2 idle");
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2 scl after start", int'(scl_o), 0);
    chk("R2 fall strobe after start", int'(fall_stb), 1);
    repeat (4) @(negedge clk);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R9 scl after stop", int'(scl_o), 1);
    chk("R9 rise strobe after stop", int'(rise_stb), 1);
    begin
      int bad = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!scl_o || fall_stb || rise_stb) bad++;
      end
      chk("R9 idle after stop", bad, 0);
    end
    @(negedge clk); start = 1'b1; stop = 1'b1;
    @(negedge clk); start = 1'b0; stop = 1'b0;
    begin
      int bad = 0;
      for (int i = 0; i < 10; i++) begin
        if (!scl_o || fall_stb || rise_stb) bad++;
        @(negedge clk);
      end
      chk("R9 stop wins over start", bad, 0);
      chk("R1 idle strobes", int'({fall_stb, rise_stb}), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule